// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. Its transmitter takes a parallel word through a valid/ready handshake and shifts it onto a serial line. Its receiver rebuilds words from an incoming serial line and checks them. The line idles high. Each frame has four parts, sent in this order: one low start bit, the data bits with the least significant bit first, an optional parity bit, and one or two high stop bits.

The frame format is set at run time by three encoded inputs: a character-size code, a parity code and a stop-count select. Both directions read this format only when a frame begins, so a change made during a frame affects only later frames. Bit timing comes from an external tick at sixteen times the baud rate. The receiver finds the start bit at mid-bit and samples every later bit at its centre. It reports a parity error flag and a framing error flag together with each received word.

Top module: `serial_xcvr`

## Requirements
- R1: After reset, `txd` is high, `tx_ready` is high and `rx_valid` is low.
- R2: A transmitted frame is a low start bit, then the data bits least significant bit first, then the parity bit when enabled, then high stop bits. Each bit lasts 16 ticks of `os_tick`.
- R3: `cfg_size` selects the data length for both directions: 000=5, 001=6, 010=7, 011=8, 111=9 bits. The reserved codes 100, 101 and 110 select 8 bits.
- R4: `cfg_parity` encodes 00=no parity, 01=reserved (treated as no parity), 10=even, 11=odd. With even parity the data bits plus the parity bit hold an even number of ones; with odd parity they hold an odd number.
- R5: The transmitter sends one stop bit when `cfg_two_stop` is 0 and two when it is 1. From acceptance until `tx_ready` returns high, exactly (1 + length + parity + stops) x 16 ticks are consumed.
- R6: The receiver checks only the first stop bit. It ignores `cfg_two_stop` and accepts back-to-back frames that have a single stop bit.
- R7: If parity is enabled and the received parity bit does not match, `rx_parity_err` is 1 alongside the word. The word is still delivered.
- R8: If the first stop bit is sampled low, `rx_frame_err` is 1 alongside the word and the word is still delivered. The receiver then starts a new frame only after the line has been high and falls again.
- R9: Received bits above the configured length read as zero. Transmit bits above the configured length are not sent.
- R10: The transmitter takes the format when it accepts a word, and the receiver takes it when it detects a start bit. Changing the configuration mid-frame does not alter that frame.
- R11: A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low until the last stop bit has ended.
- R12: `rx_valid` is a single-cycle pulse. `rx_data` and both error flags hold their values until the next word is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling tick at 16x the baud rate |
| cfg_parity | input | 2 | Parity code |
| cfg_two_stop | input | 1 | Transmit stop-count select |
| cfg_size | input | 3 | Character-size code |
| tx_data | input | 9 | Word to transmit |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Transmitter able to accept a word |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_data | output | 9 | Last received word, zero-filled |
| rx_valid | output | 1 | Pulse when a received word is delivered |
| rx_parity_err | output | 1 | Parity mismatch for the delivered word |
| rx_frame_err | output | 1 | First stop bit was low for the delivered word |

## Verification
The hardest case to reach is a framing error followed by a line that stays low. Driving it requires a transmitter that breaks its own stop bit, which a looped-back transmitter never does. For this case the bench stops looping back and drives the receive line itself, bit by bit. It sends frames with a low stop bit, frames with a wrong parity bit, and single-stop frames sent back to back, then holds the line low for several bit times to check that no extra word appears. For changes made mid-frame, the bench rewrites the configuration after both directions have started a frame, and then checks the frame length and the received word against the old format.

// File: rtl/sxcvr_pkg.sv
package sxcvr_pkg;

    localparam int DW = 9;
    localparam int LW = 4;

    typedef enum logic [2:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_PAR,
        LN_STOP
    } ln_state_t;

    typedef struct packed {
        logic [LW-1:0] len;
        logic          par_en;
        logic          par_odd;
        logic          stop2;
    } fmt_t;

    function automatic fmt_t decode_fmt(logic [1:0] par_code, logic two_stop,
                                        logic [2:0] size_code);
        fmt_t f;
        case (size_code)
            3'b000:  f.len = LW'(5);
            3'b001:  f.len = LW'(6);
            3'b010:  f.len = LW'(7);
            3'b111:  f.len = LW'(9);
            default: f.len = LW'(8);
        endcase
        f.par_en  = par_code[1];
        f.par_odd = par_code[0];
        f.stop2   = two_stop;
        return f;
    endfunction

    function automatic logic [DW-1:0] len_mask(logic [LW-1:0] len);
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++) begin
            m[i] = (i < int'(len));
        end
        return m;
    endfunction

    function automatic logic parity_of(logic [DW-1:0] d, logic [LW-1:0] len,
                                       logic odd);
        return (^(d & len_mask(len))) ^ odd;
    endfunction

endpackage

// File: rtl/sxcvr_sync.sv
module sxcvr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sxcvr_tx.sv
module sxcvr_tx
    import sxcvr_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          os_tick,
    input  fmt_t          fmt_in,
    input  logic [DW-1:0] data_in,
    input  logic          valid_in,
    output logic          ready_out,
    output logic          txd
);
    localparam int CW = $clog2(OS);
    localparam logic [CW-1:0] CNT_LAST = CW'(OS - 1);

    ln_state_t     state;
    logic [CW-1:0] cnt;
    logic [LW-1:0] bit_idx;
    logic [DW-1:0] shreg;
    fmt_t          fmt_q;
    logic          par_bit;
    logic          stop_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= LN_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            fmt_q     <= '0;
            par_bit   <= 1'b0;
            stop_left <= 1'b0;
        end else if (state == LN_IDLE) begin
            if (valid_in) begin
                shreg     <= data_in & len_mask(fmt_in.len);
                fmt_q     <= fmt_in;
                par_bit   <= parity_of(data_in, fmt_in.len, fmt_in.par_odd);
                stop_left <= fmt_in.stop2;
                cnt       <= '0;
                bit_idx   <= '0;
                state     <= LN_START;
            end
        end else if (os_tick) begin
            if (cnt == CNT_LAST) begin
                cnt <= '0;
                case (state)
                    LN_START: state <= LN_DATA;
                    LN_DATA: begin
                        shreg   <= shreg >> 1;
                        bit_idx <= bit_idx + LW'(1);
                        if (bit_idx == fmt_q.len - LW'(1))
                            state <= fmt_q.par_en ? LN_PAR : LN_STOP;
                    end
                    LN_PAR:  state <= LN_STOP;
                    LN_STOP: begin
                        if (stop_left) stop_left <= 1'b0;
                        else           state     <= LN_IDLE;
                    end
                    default: state <= LN_IDLE;
                endcase
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    always_comb begin
        case (state)
            LN_START: txd = 1'b0;
            LN_DATA:  txd = shreg[0];
            LN_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end

    assign ready_out = (state == LN_IDLE);

    p_accept_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_out) |-> $past(valid_in));

    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_out) |-> !txd);

    p_line_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!ready_out && !os_tick) |=> $stable(txd));

endmodule

// File: rtl/sxcvr_rx.sv
module sxcvr_rx
    import sxcvr_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          os_tick,
    input  logic          rx_s,
    input  logic [LW-1:0] len_in,
    input  logic          par_en_in,
    input  logic          par_odd_in,
    output logic [DW-1:0] data_out,
    output logic          valid_out,
    output logic          par_err_out,
    output logic          frm_err_out
);
    localparam int CW = $clog2(OS);
    localparam logic [CW-1:0] CNT_LAST = CW'(OS - 1);
    localparam logic [CW-1:0] CNT_HALF = CW'(OS / 2 - 1);

    ln_state_t     state;
    logic [CW-1:0] cnt;
    logic [LW-1:0] bit_idx;
    logic [DW-1:0] acc;
    logic [LW-1:0] len_q;
    logic          par_en_q;
    logic          par_odd_q;
    logic          par_rx;
    logic          prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= LN_IDLE;
            cnt         <= '0;
            bit_idx     <= '0;
            acc         <= '0;
            len_q       <= LW'(8);
            par_en_q    <= 1'b0;
            par_odd_q   <= 1'b0;
            par_rx      <= 1'b0;
            prev        <= 1'b0;
            data_out    <= '0;
            valid_out   <= 1'b0;
            par_err_out <= 1'b0;
            frm_err_out <= 1'b0;
        end else begin
            valid_out <= 1'b0;
            if (os_tick) begin
                prev <= rx_s;
                if (state == LN_IDLE) begin
                    if (prev && !rx_s) begin
                        state     <= LN_START;
                        cnt       <= '0;
                        bit_idx   <= '0;
                        acc       <= '0;
                        len_q     <= len_in;
                        par_en_q  <= par_en_in;
                        par_odd_q <= par_odd_in;
                    end
                end else if (state == LN_START) begin
                    if (cnt == CNT_HALF) begin
                        cnt   <= '0;
                        state <= rx_s ? LN_IDLE : LN_DATA;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end else if (cnt == CNT_LAST) begin
                    cnt <= '0;
                    case (state)
                        LN_DATA: begin
                            acc[bit_idx] <= rx_s;
                            bit_idx      <= bit_idx + LW'(1);
                            if (bit_idx == len_q - LW'(1))
                                state <= par_en_q ? LN_PAR : LN_STOP;
                        end
                        LN_PAR: begin
                            par_rx <= rx_s;
                            state  <= LN_STOP;
                        end
                        default: begin
                            data_out    <= acc;
                            valid_out   <= 1'b1;
                            par_err_out <= par_en_q &&
                                           (par_rx != parity_of(acc, len_q, par_odd_q));
                            frm_err_out <= !rx_s;
                            state       <= LN_IDLE;
                        end
                    endcase
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    p_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        valid_out |=> !valid_out);

    p_zero_fill_r9: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> ((data_out & ~len_mask(len_q)) == '0));

    p_no_par_err_r4: assert property (@(posedge clk) disable iff (rst)
        (valid_out && !par_en_q) |-> !par_err_out);

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !valid_out |-> ($stable(data_out) && $stable(frm_err_out)));

endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
    import sxcvr_pkg::*;
#(
    parameter int OS          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          os_tick,
    input  logic [1:0]    cfg_parity,
    input  logic          cfg_two_stop,
    input  logic [2:0]    cfg_size,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    output logic          txd,
    input  logic          rxd,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          rx_parity_err,
    output logic          rx_frame_err
);
    fmt_t fmt;
    logic rx_s;

    assign fmt = decode_fmt(cfg_parity, cfg_two_stop, cfg_size);

    sxcvr_tx #(.OS(OS)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .os_tick   (os_tick),
        .fmt_in    (fmt),
        .data_in   (tx_data),
        .valid_in  (tx_valid),
        .ready_out (tx_ready),
        .txd       (txd)
    );

    sxcvr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd),
        .q   (rx_s)
    );

    sxcvr_rx #(.OS(OS)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .os_tick     (os_tick),
        .rx_s        (rx_s),
        .len_in      (fmt.len),
        .par_en_in   (fmt.par_en),
        .par_odd_in  (fmt.par_odd),
        .data_out    (rx_data),
        .valid_out   (rx_valid),
        .par_err_out (rx_parity_err),
        .frm_err_out (rx_frame_err)
    );

    p_idle_line_r1: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> txd);

endmodule

// File: tb/serial_xcvr_tb.sv
module serial_xcvr_tb;
    localparam int OS = 16;
    localparam int BITCLK = 2 * OS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] cfg_par = 2'b00;
    logic       cfg_s2 = 1'b0;
    logic [2:0] cfg_sz = 3'b011;
    logic [8:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready, txd;
    logic       loop_sel = 1'b1;
    logic       rxd_drv = 1'b1;
    logic       rxd;
    logic [8:0] rx_data;
    logic       rx_valid, rx_pe, rx_fe;

    int vectors = 0;
    int fails = 0;
    int tick_cnt = 0;
    int got_cnt = 0;
    logic [8:0] cap_data = '0;
    logic cap_pe = 1'b0, cap_fe = 1'b0;
    logic [1:0] div = '0;

    assign rxd = loop_sel ? txd : rxd_drv;

    always #4 clk = ~clk;

    serial_xcvr u_dut (
        .clk(clk), .rst(rst), .os_tick(tick),
        .cfg_parity(cfg_par), .cfg_two_stop(cfg_s2), .cfg_size(cfg_sz),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_parity_err(rx_pe), .rx_frame_err(rx_fe)
    );

    always @(negedge clk) begin
        if (rst) begin
            div  <= '0;
            tick <= 1'b0;
        end else begin
            div  <= div + 2'd1;
            tick <= div[0];
            if (div[0] && !tx_ready) tick_cnt = tick_cnt + 1;
        end
        if (!rst && rx_valid) begin
            got_cnt  = got_cnt + 1;
            cap_data = rx_data;
            cap_pe   = rx_pe;
            cap_fe   = rx_fe;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [2:0] sz);
        case (sz)
            3'd0: return 5;
            3'd1: return 6;
            3'd2: return 7;
            3'd7: return 9;
            default: return 8;
        endcase
    endfunction

    function automatic int expected_parity_bit(input logic [8:0] d, input int n, input logic odd);
        int ones = 0;
        for (int i = 0; i < n; i++) ones += d[i];
        return (ones % 2) ^ int'(odd);
    endfunction

    // Loopback frame; chg rewrites the configuration mid-frame (R10)
    task automatic run_frame(input logic [1:0] par, input logic s2, input logic [2:0] sz,
                             input logic [8:0] d, input bit chg);
        int n, pe, exp_ticks, g0, t;
        n = exp_len(sz);
        pe = par[1] ? 1 : 0;
        exp_ticks = (1 + n + pe + 1 + int'(s2)) * OS;
        loop_sel = 1'b1;
        @(negedge clk);
        g0 = got_cnt;
        cfg_par = par; cfg_s2 = s2; cfg_sz = sz;
        tx_data = d; tx_valid = 1'b1; tick_cnt = 0;
        @(negedge clk);
        tx_valid = 1'b0;
        t = 0;
        while ((got_cnt == g0 || !tx_ready) && t < 4000) begin
            @(negedge clk);
            t++;
            if (chg && t == 100) begin
                cfg_par = 2'b10; cfg_s2 = ~s2; cfg_sz = 3'b000;
            end
        end
        check("R2 R3 R9 rx word", int'(cap_data), int'(d & 9'((1 << n) - 1)));
        check("R4 R7 parity flag clear", int'(cap_pe), 0);
        check("R6 R8 frame flag clear", int'(cap_fe), 0);
        check("R5 R11 ticks per frame", tick_cnt, exp_ticks);
        check("R12 one word", got_cnt - g0, 1);
    endtask

    // Bench-driven receive frame; the line is left at the stop value
    task automatic send_raw(input int n, input logic [8:0] d, input bit has_par,
                            input logic pbit, input logic stop);
        loop_sel = 1'b0;
        rxd_drv = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rxd_drv = d[i];
            repeat (BITCLK) @(negedge clk);
        end
        if (has_par) begin
            rxd_drv = pbit;
            repeat (BITCLK) @(negedge clk);
        end
        rxd_drv = stop;
        repeat (BITCLK) @(negedge clk);
    endtask

    bit done = 0;

    initial begin
        int g0;
        logic [8:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 txd idle", int'(txd), 1);
        check("R1 tx_ready", int'(tx_ready), 1);
        check("R1 rx_valid", int'(rx_valid), 0);
        repeat (40) @(negedge clk);

        // R2 R3 R4 R5 R6 R9 R11: sweep every size, parity and stop code
        for (int sz = 0; sz < 8; sz++)
            for (int p = 0; p < 4; p++)
                for (int s = 0; s < 2; s++)
                    for (int k = 0; k < 3; k++) begin
                        d = 9'((sz * 37 + p * 11 + s * 101 + k * 171 + 9'h155 * (k % 2)) & 9'h1FF);
                        run_frame(2'(p), 1'(s), 3'(sz), d, 1'b0);
                    end

        // R10 configuration rewritten mid-frame
        run_frame(2'b00, 1'b0, 3'b011, 9'h15A, 1'b1);
        run_frame(2'b11, 1'b1, 3'b111, 9'h1C3, 1'b1);

        // R7 parity mismatch, even, data 0x01 needs parity 1, send 0
        cfg_par = 2'b10; cfg_s2 = 1'b0; cfg_sz = 3'b011;
        rxd_drv = 1'b1; loop_sel = 1'b0;
        repeat (BITCLK) @(negedge clk);
        g0 = got_cnt;
        send_raw(8, 9'h001, 1, 1'b0, 1'b1);
        repeat (BITCLK) @(negedge clk);
        check("R7 even mismatch flag", int'(cap_pe), 1);
        check("R7 word delivered", int'(cap_data), 1);
        check("R7 one word", got_cnt - g0, 1);
        // R7 odd parity, data 0x03: correct bit is 1
        cfg_par = 2'b11;
        send_raw(8, 9'h003, 1, 1'(expected_parity_bit(9'h003, 8, 1'b1)), 1'b1);
        repeat (BITCLK) @(negedge clk);
        check("R7 odd correct no flag", int'(cap_pe), 0);
        send_raw(8, 9'h003, 1, 1'b0, 1'b1);
        repeat (BITCLK) @(negedge clk);
        check("R7 odd mismatch flag", int'(cap_pe), 1);

        // R6 two-stop select ignored by receiver: back-to-back single-stop frames
        cfg_par = 2'b00; cfg_s2 = 1'b1; cfg_sz = 3'b010;
        g0 = got_cnt;
        send_raw(7, 9'h055, 0, 1'b0, 1'b1);
        send_raw(7, 9'h02A, 0, 1'b0, 1'b1);
        repeat (BITCLK) @(negedge clk);
        check("R6 both words", got_cnt - g0, 2);
        check("R6 second word", int'(cap_data), 9'h02A);
        check("R6 no frame error", int'(cap_fe), 0);

        // R8 framing error, line stays low, then resync
        cfg_s2 = 1'b0; cfg_sz = 3'b011;
        g0 = got_cnt;
        send_raw(8, 9'h0A7, 0, 1'b0, 1'b0);
        repeat (3 * BITCLK) @(negedge clk);
        check("R8 frame error flag", int'(cap_fe), 1);
        check("R8 word delivered", int'(cap_data), 9'h0A7);
        check("R8 no restart while low", got_cnt - g0, 1);
        rxd_drv = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        check("R8 none on rise", got_cnt - g0, 1);
        send_raw(8, 9'h03C, 0, 1'b0, 1'b1);
        repeat (BITCLK) @(negedge clk);
        check("R8 resync word", int'(cap_data), 9'h03C);
        check("R8 resync flag clear", int'(cap_fe), 0);
        check("R12 flags held", int'(rx_fe), 0);

        // R3 R9 9-bit receive with top bit, 5-bit receive zero-fill
        cfg_sz = 3'b111;
        send_raw(9, 9'h1F0, 0, 1'b0, 1'b1);
        repeat (BITCLK) @(negedge clk);
        check("R3 nine-bit word", int'(cap_data), 9'h1F0);
        cfg_sz = 3'b000;
        send_raw(5, 9'h01F, 0, 1'b0, 1'b1);
        rxd_drv = 1'b1;
        repeat (BITCLK) @(negedge clk);
        check("R9 zero fill", int'(cap_data), 9'h01F);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule